// File: doc/BRIEF.md
# Parallel CRC-11 engine with byte-granular tail

This block folds a stream of 64-bit words into an 11-bit cyclic redundancy check. It absorbs one full word per clock. The generator has the low coefficients 0x621, which are taps at bits 10, 9, 5 and 0. The result equals a bit-serial shift register that takes the most significant input bit of each word first. The block reaches this by reversing the word's bit order internally before the parallel update. A frame is opened by a start strobe and closed by an end strobe. On the closing word a byte count says how many leading bytes carry data.

A short final word is not padded with zeros, because padding would change the check value. Instead the block keeps eight parallel update networks, covering 8, 16 through 56 and 64 bits, all fed from the same register. A selector picks the network that matches the valid width of the word. The check value stays on the output after the frame ends, and a one-cycle done pulse marks it as final.

Top module: `crc11_tail_engine`

## Requirements
- R1: While reset is held and after it is released, `crc_out` is 0 and `crc_done` is 0 until a word is absorbed.
- R2: A full word updates the register exactly like 64 serial steps. Bit 63 is fed first and bit 0 last. Each step computes fb = crc[10] ^ bit, shifts the register left by one, and XORs 0x621 into it when fb is 1.
- R3: A single-word frame holding 0x0000_0000_0000_0001, starting from zero, yields `crc_out` = 0x621.
- R4: When `in_valid` and `in_sof` are high together, the register is treated as zero before that same word is absorbed, even in the middle of a frame.
- R5: On an end word, `in_bytes` = 0 means all 8 bytes are valid. A value k from 1 to 7 means only the leading bytes, bits 63 down to 64-8k, are absorbed. The lower bits of the word have no effect on the result.
- R6: Successive valid words of one frame chain: each word starts from the value left by the previous one.
- R7: `crc_done` is 1 in the cycle after a valid end word and 0 in every other cycle.
- R8: While `in_valid` is low, `crc_out` keeps its value. This includes the time after a frame until the next start.
- R9: On a valid word with `in_eof` low, `in_bytes` has no effect: the full 64 bits are absorbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | A data word is present this cycle |
| in_sof | input | 1 | This word opens a frame (register cleared first) |
| in_eof | input | 1 | This word closes a frame |
| in_bytes | input | 3 | Valid leading bytes of the end word, 0 meaning 8 |
| in_data | input | 64 | Data word, bit 63 absorbed first |
| crc_out | output | 11 | Current check register |
| crc_done | output | 1 | One-cycle pulse after the end word is absorbed |

## Verification
The hardest case to reach from the ports is a short tail whose ignored low bytes differ from zero, combined with a frame that began several words earlier. A wrong width selection or any hidden padding only shows up in that case. The stimulus therefore sends multi-word frames for every tail length from 1 to 8 bytes, with random filler in the unused bytes. It also places the same leading bytes before different filler. Further stimulus restarts a frame with a start strobe in mid-frame, puts end words back to back, and leaves idle gaps between words.

// File: rtl/crc11_pkg.sv
package crc11_pkg;
  localparam int unsigned CRC_W_DEF  = 11;
  localparam int unsigned DATA_W_DEF = 64;
  localparam logic [CRC_W_DEF-1:0] POLY_DEF = 11'h621;
endpackage

// File: rtl/crc11_rst_sync.sv
module crc11_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/crc11_bitrev.sv
module crc11_bitrev #(
  parameter int unsigned DATA_W = crc11_pkg::DATA_W_DEF
) (
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_rev
);
  for (genvar b = 0; b < DATA_W; b++) begin : g_rev
    assign data_rev[b] = data_in[DATA_W-1-b];
  end
endmodule

// File: rtl/crc11_lane.sv
module crc11_lane #(
  parameter int unsigned CRC_W = crc11_pkg::CRC_W_DEF,
  parameter logic [CRC_W-1:0] POLY = crc11_pkg::POLY_DEF,
  parameter int unsigned NBITS = 8
) (
  input  logic [CRC_W-1:0] crc_in,
  input  logic [NBITS-1:0] bits_in,   // bit 0 is absorbed first
  output logic [CRC_W-1:0] crc_next
);
  always_comb begin
    logic [CRC_W-1:0] acc;
    logic             fb;
    acc = crc_in;
    for (int i = 0; i < int'(NBITS); i++) begin
      fb  = acc[CRC_W-1] ^ bits_in[i];
      acc = {acc[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
    crc_next = acc;
  end
endmodule

// File: rtl/crc11_tail_sel.sv
module crc11_tail_sel #(
  parameter int unsigned CRC_W  = crc11_pkg::CRC_W_DEF,
  parameter int unsigned NLANES = 8,
  localparam int unsigned SEL_W = (NLANES > 1) ? $clog2(NLANES) : 1
) (
  input  logic [NLANES-1:0][CRC_W-1:0] lane_crc,
  input  logic [SEL_W-1:0]             sel,
  output logic [CRC_W-1:0]             crc_sel
);
  always_comb begin
    crc_sel = lane_crc[NLANES-1];
    for (int l = 0; l < int'(NLANES); l++) begin
      if (sel == SEL_W'(l)) crc_sel = lane_crc[l];
    end
  end
endmodule

// File: rtl/crc11_tail_engine.sv
module crc11_tail_engine #(
  parameter int unsigned CRC_W  = crc11_pkg::CRC_W_DEF,
  parameter int unsigned DATA_W = crc11_pkg::DATA_W_DEF,
  parameter logic [CRC_W-1:0] POLY = crc11_pkg::POLY_DEF,
  localparam int unsigned NLANES = DATA_W / 8,
  localparam int unsigned BYTE_W = $clog2(NLANES),
  localparam int unsigned SEL_W  = (NLANES > 1) ? $clog2(NLANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [BYTE_W-1:0] in_bytes,
  input  logic [DATA_W-1:0] in_data,
  output logic [CRC_W-1:0]  crc_out,
  output logic              crc_done
);
  logic rst_n_sync;
  crc11_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync));

  logic [CRC_W-1:0]             crc_q, crc_d, crc_base;
  logic                         done_q, done_d;
  logic [DATA_W-1:0]            data_rev;
  logic [NLANES-1:0][CRC_W-1:0] lane_crc;
  logic [SEL_W-1:0]             sel;

  crc11_bitrev #(.DATA_W(DATA_W)) u_rev (.data_in(in_data), .data_rev(data_rev));

  assign crc_base = in_sof ? '0 : crc_q;

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    crc11_lane #(.CRC_W(CRC_W), .POLY(POLY), .NBITS((g + 1) * 8)) u_lane (
      .crc_in  (crc_base),
      .bits_in (data_rev[(g+1)*8-1:0]),
      .crc_next(lane_crc[g])
    );
  end

  // Width select: full word unless this is a short end word
  always_comb begin
    if (in_eof && (in_bytes != '0)) sel = SEL_W'(in_bytes - 1'b1);
    else                            sel = SEL_W'(NLANES - 1);
  end

  crc11_tail_sel #(.CRC_W(CRC_W), .NLANES(NLANES)) u_sel (
    .lane_crc(lane_crc), .sel(sel), .crc_sel(crc_d)
  );

  assign done_d = in_valid & in_eof;

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      crc_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (in_valid) crc_q <= crc_d;
      done_q <= done_d;
    end
  end

  assign crc_out  = crc_q;
  assign crc_done = done_q;

  AST_DONE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (in_valid && in_eof) |=> crc_done);  // R7
  AST_NO_STRAY_DONE: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !(in_valid && in_eof) |=> !crc_done);  // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !in_valid |=> $stable(crc_out));  // R8
  AST_UNIT_WORD: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (in_valid && in_sof && in_eof && in_bytes == '0 && in_data == DATA_W'(1))
      |=> (crc_out == POLY));  // R3
  AST_ZERO_BYTE_RESTART: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (in_valid && in_sof && in_eof && in_bytes == BYTE_W'(1) &&
     in_data[DATA_W-1 -: 8] == 8'h00) |=> (crc_out == '0));  // R4
endmodule

// File: tb/crc11_tail_engine_tb_top.sv
module crc11_tail_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_sof, in_eof;
  logic [2:0]  in_bytes;
  logic [63:0] in_data;
  logic [10:0] crc_out;
  logic        crc_done;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [10:0] m_crc;
  logic        m_done;

  always #4 clk = ~clk;  // 125 MHz

  crc11_tail_engine dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .in_bytes(in_bytes), .in_data(in_data),
    .crc_out(crc_out), .crc_done(crc_done)
  );

  function automatic logic [10:0] ser(input logic [10:0] c, input logic [63:0] d,
                                      input int nbits);
    for (int i = 63; i >= 64 - nbits; i--) begin
      logic fb;
      fb = c[10] ^ d[i];
      c  = {c[9:0], 1'b0};
      if (fb) c = c ^ 11'h621;
    end
    return c;
  endfunction

  task automatic check(input string req, input logic [10:0] exp_c, input logic exp_d);
    checks++;
    if (crc_out !== exp_c || crc_done !== exp_d) begin
      fails++;
      $display("FAIL %s crc=%h done=%b expected crc=%h done=%b",
               req, crc_out, crc_done, exp_c, exp_d);
    end
  endtask

  // One clock: drive, advance model, compare after the edge
  task automatic cyc(input string req, input bit v, input bit s, input bit e,
                     input logic [2:0] b, input logic [63:0] d);
    int n;
    in_valid = v; in_sof = s; in_eof = e; in_bytes = b; in_data = d;
    if (v) begin
      n = (e && b != 0) ? 8 * b : 64;
      m_crc = ser(s ? 11'h0 : m_crc, d, n);
    end
    m_done = v && e;
    @(posedge clk); #1;
    check(req, m_crc, m_done);
  endtask

  task automatic frame(input string req, input int words, input logic [2:0] tail,
                       input bit gaps);
    for (int w = 0; w < words; w++) begin
      logic [63:0] d;
      d = {$urandom, $urandom};
      cyc(req, 1'b1, w == 0, w == words - 1, (w == words - 1) ? tail : 3'($urandom), d);
      if (gaps && ($urandom % 2)) cyc("R8", 1'b0, 1'b0, 1'b0, 3'd0, 64'h0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    in_valid = 0; in_sof = 0; in_eof = 0; in_bytes = 0; in_data = 0;
    m_crc = 0; m_done = 0;
    rst_n = 0;
    repeat (3) @(posedge clk); #1;
    check("R1", 11'h0, 1'b0);
    rst_n = 1;
    repeat (4) @(posedge clk); #1;
    check("R1", 11'h0, 1'b0);

    // R3 unit word
    cyc("R3", 1, 1, 1, 3'd0, 64'h1);
    if (crc_out !== 11'h621) begin
      fails++; $display("FAIL R3 crc=%h expected crc=621", crc_out);
    end
    checks++;
    cyc("R8", 0, 0, 0, 3'd5, 64'hFFFF);
    cyc("R8", 0, 0, 0, 3'd0, 64'h0);

    // R2 full single words of several patterns
    cyc("R2", 1, 1, 1, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    cyc("R2", 1, 1, 1, 3'd0, 64'h8000_0000_0000_0000);
    cyc("R2", 1, 1, 1, 3'd0, 64'hA5A5_5A5A_0123_4567);

    // R5 every tail length 1..8, multi-word, with idle gaps
    for (int t = 0; t < 8; t++) begin
      frame("R5", 1, 3'(t), 0);
      frame("R5", 3, 3'(t), 1);
    end

    // R5 same leading bytes, different low filler: results must match
    for (int k = 1; k < 8; k++) begin
      logic [10:0] first;
      logic [63:0] lead;
      lead = {$urandom, $urandom};
      cyc("R5", 1, 1, 1, 3'(k), lead);
      first = crc_out;
      cyc("R5", 1, 1, 1, 3'(k), lead ^ (64'hFFFF_FFFF_FFFF_FFFF >> (8 * k)));
      checks++;
      if (crc_out !== first) begin
        fails++; $display("FAIL R5 crc=%h expected crc=%h", crc_out, first);
      end
    end

    // R6 long chained frame, R9 random byte counts on non-end words
    frame("R6", 6, 3'd3, 0);
    frame("R9", 5, 3'd0, 1);

    // R4 restart in mid-frame
    cyc("R4", 1, 1, 0, 3'd2, 64'h1111_2222_3333_4444);
    cyc("R4", 1, 0, 0, 3'd0, 64'h5555_6666_7777_8888);
    cyc("R4", 1, 1, 0, 3'd0, 64'h0000_0000_0000_0001);
    cyc("R4", 1, 0, 1, 3'd4, 64'hDEAD_BEEF_0000_0000);

    // R7 back-to-back end words, then idle
    cyc("R7", 1, 1, 1, 3'd1, 64'hC300_0000_0000_0000);
    cyc("R7", 1, 1, 1, 3'd7, 64'h0102_0304_0506_07FF);
    cyc("R7", 0, 0, 1, 3'd0, 64'h0);
    cyc("R8", 0, 1, 0, 3'd0, 64'hFFFF);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule